// File: doc/BRIEF.md
# Multi-Mode Backplane Bus Arbiter with Grant Watchdog

This block is the central arbiter of a parallel backplane with four request levels. It watches four active-low request lines and the active-low bus-busy line. It drives at most one of four active-low grant lines. Software writes a small control word that selects one of three arbitration policies: fixed priority, round-robin or single-level. The same word turns a grant watchdog on or off.

A grant stays active until the winning requester takes the bus by asserting bus-busy. The grant is then dropped, and no further arbitration starts until bus-busy is released. If nobody claims the bus within 256 clocks (16 µs at a 16 MHz system clock) and the watchdog is enabled, the grant is withdrawn and the arbiter returns to idle. This keeps the bus from locking up. A newly written policy takes effect only once the arbiter is idle. The request and busy lines pass through a two-stage synchronizer before the arbiter uses them.

Top module: `arb_central`

## Requirements
- R1: After reset all four grant outputs are inactive (high), the policy is fixed priority and the watchdog is enabled.
- R2: At most one grant output is low at any time.
- R3: Policy code 2'b00 (fixed priority) grants the highest-numbered active request level; level 3 beats level 0.
- R4: Policy code 2'b01 (round-robin) gives the most recently granted level the lowest priority. The other levels rank downward from the one just below it, wrapping from 0 to 3.
- R5: Policy code 2'b10 (single-level) grants only level 3; requests on levels 0 to 2 produce no grant.
- R6: When bus-busy is asserted during a grant, the grant is released and stays released while bus-busy remains asserted, even with requests pending.
- R7: No grant is issued while bus-busy is asserted; a pending request is granted after bus-busy is negated.
- R8: With the watchdog enabled (control bit 2 = 1), an unclaimed grant stays low for exactly 256 clocks and is then withdrawn.
- R9: With the watchdog disabled (control bit 2 = 0), an unclaimed grant stays active indefinitely.
- R10: A policy written while a grant is outstanding does not change that grant; the arbitration after the arbiter goes idle uses the new policy.
- R11: The reserved policy code 2'b11 behaves as fixed priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (16 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 4 | Active-low bus requests, index = level |
| busy_n | input | 1 | Active-low bus-busy line |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 3 | Control word: [1:0] policy code, [2] watchdog enable |
| grant_n | output | 4 | Active-low bus grants, index = level |

## Verification
The bench steps round-robin through several full rotations and through sparse request patterns. A pointer that updates at the wrong time, or that wraps the wrong way, grants the wrong level. It counts the low cycles of an unclaimed grant. A watchdog that is off by one, or that ignores its enable bit, then shows 255 or 257 cycles, or never withdraws the grant. It also writes a new policy in the middle of a grant: a design that switches at once would drop or move that grant, and a design that never switches would still grant low levels afterwards. Requests held during bus-busy show whether the design re-arbitrates too early.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    MODE_PRI = 2'b00,
    MODE_RRS = 2'b01,
    MODE_SGL = 2'b10,
    MODE_RSV = 2'b11
  } arb_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_GRANT = 2'b01,
    ST_HELD  = 2'b10
  } arb_state_e;

  localparam int CFG_W = 3;
  localparam int CFG_TMR_BIT = 2;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/arb_select.sv
module arb_select
  import arb_pkg::*;
#(
  parameter int LEVELS = 4,
  localparam int IDXW = $clog2(LEVELS)
) (
  input  logic [LEVELS-1:0] req,
  input  arb_mode_e         mode,
  input  logic [IDXW-1:0]   last,
  output logic              any,
  output logic [IDXW-1:0]   win
);
  // Highest active level wins; result is {hit, index}.
  function automatic logic [IDXW:0] pick_top(input logic [LEVELS-1:0] v);
    logic [IDXW:0] r;
    r = '0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      if (!r[IDXW] && v[i]) r = {1'b1, IDXW'(i)};
    end
    return r;
  endfunction

  // Search downward from the level below the previous winner, wrapping.
  function automatic logic [IDXW:0] pick_rotate(input logic [LEVELS-1:0] v,
                                                input logic [IDXW-1:0] prev);
    logic [IDXW:0] r;
    int j;
    r = '0;
    for (int k = 1; k <= LEVELS; k++) begin
      j = (int'(prev) + LEVELS - k) % LEVELS;
      if (!r[IDXW] && v[j]) r = {1'b1, IDXW'(j)};
    end
    return r;
  endfunction

  logic [IDXW:0] top_res, rot_res;

  always_comb begin
    top_res = pick_top(req);
    rot_res = pick_rotate(req, last);
    unique case (mode)
      MODE_RRS: begin any = rot_res[IDXW]; win = rot_res[IDXW-1:0]; end
      MODE_SGL: begin any = req[LEVELS-1]; win = IDXW'(LEVELS - 1); end
      default:  begin any = top_res[IDXW]; win = top_res[IDXW-1:0]; end
    endcase
  end
endmodule

// File: rtl/arb_grant_timer.sv
module arb_grant_timer #(
  parameter int TIMEOUT = 256,
  localparam int CW = $clog2(TIMEOUT),
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT - 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic enable,
  output logic expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clear)               cnt <= '0;
    else if (run && cnt != LIMIT) cnt <= cnt + CW'(1);
  end

  assign expire = run && enable && (cnt == LIMIT);

  // R8: while a grant runs the count advances by one each cycle until it tops out
  assert_count_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(clear) && $past(cnt) != LIMIT) |-> cnt == $past(cnt) + CW'(1));
endmodule

// File: rtl/arb_central.sv
module arb_central
  import arb_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT = 256,
  localparam int IDXW = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] req_n,
  input  logic              busy_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  output logic [LEVELS-1:0] grant_n
);
  logic [LEVELS-1:0] req_n_s;
  logic              busy_n_s;
  logic [LEVELS-1:0] req_s;
  logic              busy_s;

  arb_sync #(.W(LEVELS), .STAGES(SYNC_STAGES), .RST_VAL('1)) i_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_n), .q(req_n_s));
  arb_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_busy_sync (
    .clk(clk), .rst_n(rst_n), .d(busy_n), .q(busy_n_s));

  assign req_s  = ~req_n_s;
  assign busy_s = ~busy_n_s;

  arb_state_e        state;
  arb_mode_e         mode_act, mode_pend;
  logic              tmr_en;
  logic [IDXW-1:0]   win_q, last_q;
  logic              sel_any;
  logic [IDXW-1:0]   sel_win;
  logic              tmr_expire;

  // Named events for the checks
  logic grant_issue, grant_taken, grant_expire, mode_apply;

  arb_select #(.LEVELS(LEVELS)) i_select (
    .req(req_s), .mode(mode_act), .last(last_q), .any(sel_any), .win(sel_win));

  arb_grant_timer #(.TIMEOUT(TIMEOUT)) i_timer (
    .clk(clk), .rst_n(rst_n), .clear(grant_issue), .run(state == ST_GRANT),
    .enable(tmr_en), .expire(tmr_expire));

  assign grant_issue  = (state == ST_IDLE) && !busy_s && sel_any;
  assign grant_taken  = (state == ST_GRANT) && busy_s;
  assign grant_expire = (state == ST_GRANT) && !busy_s && tmr_expire;
  assign mode_apply   = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_pend <= MODE_PRI;
      tmr_en    <= 1'b1;
    end else if (cfg_wr_en) begin
      mode_pend <= arb_mode_e'(cfg_wr_data[1:0]);
      tmr_en    <= cfg_wr_data[CFG_TMR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_act <= MODE_PRI;
    else if (mode_apply) mode_act <= mode_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      win_q  <= '0;
      last_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (grant_issue) begin
          state  <= ST_GRANT;
          win_q  <= sel_win;
          last_q <= sel_win;
        end
        ST_GRANT: begin
          if (grant_taken)       state <= ST_HELD;
          else if (grant_expire) state <= ST_IDLE;
        end
        ST_HELD: if (!busy_s) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign grant_n = (state == ST_GRANT) ? ~(LEVELS'(1) << win_q) : '1;

  // R2: never more than one grant low
  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~grant_n));
  // R7: a grant only begins after a cycle with the bus free
  assert_grant_on_free_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GRANT && $past(state) == ST_IDLE) |-> !$past(busy_s));
  // R6: takeover drops the grant next cycle
  assert_taken_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_taken |=> grant_n == '1);
  // R6: no grant while the bus is held
  assert_held_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HELD) |-> grant_n == '1);
  // R8: watchdog expiry withdraws the grant
  assert_expire_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_expire |=> grant_n == '1);
  // R5: single-level arbitration only ever picks the top level
  assert_sgl_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GRANT && $past(state) == ST_IDLE && $past(mode_act) == MODE_SGL)
      |-> win_q == IDXW'(LEVELS - 1));
  // R10: the active policy moves only out of idle
  assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_act) |-> $past(state) == ST_IDLE);
  // R3: the winner is always a level that requested
  assert_winner_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_issue |-> req_s[sel_win]);
endmodule

// File: tb/test_arb_central.sv
module test_arb_central;
  localparam int LV = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LV-1:0] req_n = '1;
  logic busy_n = 1'b1;
  logic cfg_wr_en = 1'b0;
  logic [2:0] cfg_wr_data = '0;
  logic [LV-1:0] grant_n;

  int checks = 0;
  int fails = 0;
  int last_lvl = 0;
  bit finished = 0;

  arb_central i_arb_central (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .busy_n(busy_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .grant_n(grant_n));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [1:0] mode, input bit tmr);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = {tmr, mode};
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  function automatic int lvl_of(input logic [LV-1:0] g);
    for (int i = 0; i < LV; i++) if (g == ~(LV'(1) << i)) return i;
    return -1;
  endfunction

  // Bench models
  function automatic int model_pri(input logic [LV-1:0] r);
    int best = -1;
    for (int i = 0; i < LV; i++) if (r[i]) best = i;
    return best;
  endfunction

  function automatic int model_rr(input logic [LV-1:0] r, input int prev);
    int cand;
    for (int rank = 0; rank < LV; rank++) begin
      cand = prev - 1 - rank;
      if (cand < 0) cand += LV;
      if (r[cand]) return cand;
    end
    return -1;
  endfunction

  task automatic wait_grant(input int maxc, output int lvl);
    lvl = -1;
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk);
      if (grant_n != '1) begin
        lvl = lvl_of(grant_n);
        last_lvl = (lvl >= 0) ? lvl : last_lvl;
        return;
      end
    end
  endtask

  task automatic release_bus;
    busy_n = 1'b0;
    for (int c = 0; c < 8 && grant_n != '1; c++) @(negedge clk);
    req_n = '1;
    step(4);
    busy_n = 1'b1;
    step(4);
  endtask

  task automatic t_reset;
    check(grant_n == '1, "R1 grants idle after reset", int'(grant_n), 15);
  endtask

  task automatic t_priority;
    logic [LV-1:0] pats [4] = '{4'b0101, 4'b0011, 4'b0001, 4'b1111};
    int g;
    foreach (pats[p]) begin
      req_n = ~pats[p];
      wait_grant(10, g);
      check(g == model_pri(pats[p]), "R3 fixed priority winner", g, model_pri(pats[p]));
      check($countones(~grant_n) == 1, "R2 single grant", $countones(~grant_n), 1);
      release_bus();
    end
  endtask

  task automatic t_round_robin;
    logic [LV-1:0] pats [7] = '{4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1010, 4'b1010};
    int g, e;
    write_cfg(2'b01, 1'b1);
    step(2);
    foreach (pats[p]) begin
      e = model_rr(pats[p], last_lvl);
      req_n = ~pats[p];
      wait_grant(10, g);
      check(g == e, "R4 round-robin rotation", g, e);
      release_bus();
    end
  endtask

  task automatic t_single;
    int g;
    write_cfg(2'b10, 1'b1);
    step(2);
    req_n = ~4'b0111;
    wait_grant(20, g);
    check(g == -1, "R5 low levels ignored in single-level", g, -1);
    req_n = ~4'b1111;
    wait_grant(10, g);
    check(g == 3, "R5 level 3 granted in single-level", g, 3);
    release_bus();
  endtask

  task automatic t_mode_defer;
    int g;
    write_cfg(2'b00, 1'b0);
    step(2);
    req_n = ~4'b0001;
    wait_grant(10, g);
    check(g == 0, "R10 setup grant level 0", g, 0);
    write_cfg(2'b10, 1'b0);
    step(20);
    check(lvl_of(grant_n) == 0, "R10 grant kept after policy write", lvl_of(grant_n), 0);
    release_bus();
    req_n = ~4'b0001;
    wait_grant(20, g);
    check(g == -1, "R10 new policy used when idle", g, -1);
    req_n = ~4'b1001;
    wait_grant(10, g);
    check(g == 3, "R10 new policy grants level 3", g, 3);
    release_bus();
  endtask

  task automatic t_timeout;
    int g, cnt;
    write_cfg(2'b00, 1'b1);
    step(2);
    req_n = ~4'b0010;
    wait_grant(10, g);
    check(g == 1, "R8 grant level 1", g, 1);
    req_n = '1;
    cnt = 1;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (grant_n == '1) break;
      cnt++;
    end
    check(cnt == 256, "R8 watchdog window length", cnt, 256);
    wait_grant(20, g);
    check(g == -1, "R8 grant withdrawn", g, -1);
  endtask

  task automatic t_no_timeout;
    int g;
    write_cfg(2'b00, 1'b0);
    step(2);
    req_n = ~4'b0100;
    wait_grant(10, g);
    req_n = '1;
    step(600);
    check(lvl_of(grant_n) == 2, "R9 grant held with watchdog off", lvl_of(grant_n), 2);
    release_bus();
  endtask

  task automatic t_busy;
    int g;
    write_cfg(2'b00, 1'b1);
    step(2);
    busy_n = 1'b0;
    step(4);
    req_n = ~4'b1000;
    wait_grant(20, g);
    check(g == -1, "R7 no grant while bus busy", g, -1);
    busy_n = 1'b1;
    wait_grant(10, g);
    check(g == 3, "R7 grant after bus freed", g, 3);
    busy_n = 1'b0;
    step(5);
    check(grant_n == '1, "R6 grant released on takeover", int'(grant_n), 15);
    req_n = ~4'b0110;
    wait_grant(20, g);
    check(g == -1, "R6 no regrant while busy held", g, -1);
    req_n = '1;
    step(4);
    busy_n = 1'b1;
    step(4);
  endtask

  task automatic t_reserved;
    int g;
    write_cfg(2'b11, 1'b1);
    step(2);
    req_n = ~4'b0110;
    wait_grant(10, g);
    check(g == 2, "R11 reserved code acts as fixed priority", g, 2);
    release_bus();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_priority();
    t_round_robin();
    t_single();
    t_mode_defer();
    t_timeout();
    t_no_timeout();
    t_busy();
    t_reserved();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule